// File: doc/BRIEF.md
# Register-Mapped Random Word Generator

This block is a small peripheral that hands random 32-bit words to a host over a simple single-cycle register bus. A 32-bit maximal-length linear feedback shift register advances once per clock. Every generation interval, it offers its current state to a one-word output slot. The host starts the block by setting a start bit, which cannot be cleared by software. The host then polls a level field in the status register and reads the output register. That read returns the word and empties the slot in the same cycle.

Software can write entropy words into a write-only register, and those words are XORed into the generator state. A single-bit noise input, which stands in for a physical noise source, is folded into the feedback on every step. A sleep state freezes the generator and the interval counter. It is entered either through a control bit or through an external doze input. While sleeping, a word already held in the slot can still be read.

Top module: `rng_periph`

## Requirements
- R1: After reset the control, status, output and entropy registers all read as zero.
- R2: The start bit is control bit 0. Writing 1 to it sets it, and it stays 1 until reset. A later control write with bit 0 at 0 leaves it set.
- R3: Control bit 4 is the sleep request. Status bit 4 reads 1 whenever sleep is in effect, that is, when control bit 4 is 1 or the doze input is high.
- R4: A high doze input puts the block in sleep exactly as control bit 4 would, with control bit 4 still reading 0.
- R5: Status bits 15:8 hold the slot level. A value of 0 means the slot is empty and 1 means one word is waiting. No other value appears.
- R6: A read of the output register while the level is 1 returns the stored word. At that clock edge the level and the output register both become 0, so that an immediate second read returns 0.
- R7: The entropy register reads as zero. A write to it XORs the written word into the generator state at that clock edge, after the normal step when not sleeping.
- R8: No word is ever loaded while the start bit is 0.
- R9: The generator steps as state <= {state[30:0], s31^s21^s1^s0^noise}. A word, equal to the current generator state, is loaded at an edge where the level is 0, the start bit is 1, sleep is not in effect and the interval counter has reached GEN_CYCLES (32). The counter restarts from 0 at each load or clearing read, and it advances on each non-sleeping edge.
- R10: While sleep is in effect the generator state (apart from entropy writes) and the interval counter hold, and a word already in the slot remains readable.
- R11: A generator update that would produce the all-zero state produces the value 1 instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address: 0x0 control, 0x4 status, 0x8 output, 0xC entropy |
| bus_we | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_rdata | output | 32 | Read data, combinational from address and state while bus_re is high, else 0 |
| doze_i | input | 1 | External sleep request |
| noise_i | input | 1 | Noise bit folded into the generator feedback |

## Verification
Read data is combinational, so each read is checked in the same cycle in which it is driven, against a bench model that is advanced at the same clock edges as the design. A write or a clearing read becomes visible at the next cycle's read. After a clearing read, the level field must next read 1 on the (GEN_CYCLES+2)-th cycle after the cycle of the read, which is GEN_CYCLES+1 clock edges after the read's edge, and the bench checks that cycle directly. Inputs are driven on the falling edge and read data is sampled one time unit later, well away from the rising edge at which the design and the model update.

// File: rtl/rng_pkg.sv
package rng_pkg;
   typedef enum logic [1:0] {
      RSEL_CTRL = 2'd0,
      RSEL_STAT = 2'd1,
      RSEL_OUT  = 2'd2,
      RSEL_ENT  = 2'd3
   } rsel_e;

   localparam int CTRL_GO_BIT  = 0;
   localparam int CTRL_SLP_BIT = 4;
   localparam int STAT_SLP_BIT = 4;
   localparam int STAT_LVL_LSB = 8;
   localparam int SEL_LSB      = 2;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
   parameter int          W        = 32,
   parameter logic [W-1:0] TAP_MASK = 32'h8020_0003,
   parameter logic [W-1:0] NZ_FILL  = 32'h0000_0001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         noise,
   input  logic         mix_en,
   input  logic [W-1:0] mix_val,
   output logic [W-1:0] state
);
   if (W < 2) begin : g_bad_w
      $error("rng_lfsr: W must be at least 2");
   end
   if (NZ_FILL == '0) begin : g_bad_fill
      $error("rng_lfsr: NZ_FILL must be nonzero");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] nxt;
   logic         upd;
   logic         fb;

   assign fb = (^(state_q & TAP_MASK)) ^ noise;

   always_comb begin
      nxt = state_q;
      upd = 1'b0;
      if (!hold) begin
         nxt = {state_q[W-2:0], fb};
         upd = 1'b1;
      end
      if (mix_en) begin
         nxt = nxt ^ mix_val;
         upd = 1'b1;
      end
      if (upd && (nxt == '0)) begin
         nxt = NZ_FILL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= nxt;
   end

   assign state = state_q;
endmodule

// File: rtl/rng_pace.sv
module rng_pace #(
   parameter int GEN_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic due
);
   localparam int CW = $clog2(GEN_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(GEN_CYCLES);

   if (GEN_CYCLES < 1) begin : g_bad_gen
      $error("rng_pace: GEN_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (restart)               cnt_q <= '0;
      else if (run && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign due = (cnt_q == LIMIT);
endmodule

// File: rtl/rng_slot.sv
module rng_slot #(
   parameter int W     = 32,
   parameter int LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [W-1:0]     load_val,
   input  logic             take,
   output logic [W-1:0]     word,
   output logic [LVL_W-1:0] level
);
   if (LVL_W < 1) begin : g_bad_lvl
      $error("rng_slot: LVL_W must be at least 1");
   end

   logic [W-1:0] word_q;
   logic         full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         full_q <= 1'b0;
      end else if (load) begin
         word_q <= load_val;
         full_q <= 1'b1;
      end else if (take) begin
         word_q <= '0;
         full_q <= 1'b0;
      end
   end

   assign word  = word_q;
   assign level = LVL_W'(full_q);
endmodule

// File: rtl/rng_regs.sv
module rng_regs
   import rng_pkg::*;
#(
   parameter int W      = 32,
   parameter int ADDR_W = 4,
   parameter int LVL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [W-1:0]      bus_wdata,
   input  logic              bus_re,
   output logic [W-1:0]      bus_rdata,
   input  logic [LVL_W-1:0]  level,
   input  logic [W-1:0]      word,
   input  logic              eff_sleep,
   output logic              go,
   output logic              slp_req,
   output logic              take,
   output logic              mix_en
);
   if (ADDR_W < SEL_LSB + 2) begin : g_bad_addr
      $error("rng_regs: ADDR_W too small for four registers");
   end
   if (W < STAT_LVL_LSB + LVL_W) begin : g_bad_w
      $error("rng_regs: W too small for the status layout");
   end

   logic  hit;
   rsel_e sel;

   if (ADDR_W > SEL_LSB + 2) begin : g_upper
      assign hit = ~|bus_addr[ADDR_W-1:SEL_LSB+2];
   end else begin : g_exact
      assign hit = 1'b1;
   end

   assign sel = rsel_e'(bus_addr[SEL_LSB +: 2]);

   logic go_q;
   logic slp_q;
   logic ctrl_wr;

   assign ctrl_wr = bus_we && hit && (sel == RSEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q  <= 1'b0;
         slp_q <= 1'b0;
      end else if (ctrl_wr) begin
         go_q  <= go_q | bus_wdata[CTRL_GO_BIT];
         slp_q <= bus_wdata[CTRL_SLP_BIT];
      end
   end

   assign go      = go_q;
   assign slp_req = slp_q;
   assign take    = bus_re && hit && (sel == RSEL_OUT) && (level != '0);
   assign mix_en  = bus_we && hit && (sel == RSEL_ENT);

   always_comb begin
      bus_rdata = '0;
      if (bus_re && hit) begin
         unique case (sel)
            RSEL_CTRL: begin
               bus_rdata[CTRL_GO_BIT]  = go_q;
               bus_rdata[CTRL_SLP_BIT] = slp_q;
            end
            RSEL_STAT: begin
               bus_rdata[STAT_LVL_LSB +: LVL_W] = level;
               bus_rdata[STAT_SLP_BIT]          = eff_sleep;
            end
            RSEL_OUT:  bus_rdata = word;
            RSEL_ENT:  bus_rdata = '0;
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rng_periph.sv
module rng_periph #(
   parameter int W          = 32,
   parameter int ADDR_W     = 4,
   parameter int LVL_W      = 8,
   parameter int GEN_CYCLES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [W-1:0]      bus_wdata,
   input  logic              bus_re,
   output logic [W-1:0]      bus_rdata,
   input  logic              doze_i,
   input  logic              noise_i
);
   if (W != 32) begin : g_bad_w
      $error("rng_periph: tap set is defined for a 32-bit generator");
   end

   logic             go;
   logic             slp_req;
   logic             eff_sleep;
   logic             take;
   logic             mix_en;
   logic             due;
   logic             load;
   logic [W-1:0]     state;
   logic [W-1:0]     word;
   logic [LVL_W-1:0] level;

   assign eff_sleep = slp_req | doze_i;
   assign load      = go && !eff_sleep && due && (level == '0);

   rng_regs #(.W(W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata),
      .level     (level),
      .word      (word),
      .eff_sleep (eff_sleep),
      .go        (go),
      .slp_req   (slp_req),
      .take      (take),
      .mix_en    (mix_en)
   );

   rng_lfsr #(.W(W)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (eff_sleep),
      .noise   (noise_i),
      .mix_en  (mix_en),
      .mix_val (bus_wdata),
      .state   (state)
   );

   rng_pace #(.GEN_CYCLES(GEN_CYCLES)) u_pace (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!eff_sleep),
      .restart (load | take),
      .due     (due)
   );

   rng_slot #(.W(W), .LVL_W(LVL_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (state),
      .take     (take),
      .word     (word),
      .level    (level)
   );
endmodule

// File: rtl/rng_periph_chk.sv
module rng_periph_chk #(
   parameter int W      = 32,
   parameter int ADDR_W = 4,
   parameter int LVL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_re,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [W-1:0]      bus_rdata,
   input logic              go,
   input logic [LVL_W-1:0]  level,
   input logic [W-1:0]      word,
   input logic [W-1:0]      state,
   input logic              eff_sleep,
   input logic              mix_en,
   input logic              take,
   input logic              due
);
   a_r2_go_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> go);

   a_r5_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(1));

   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr[3:2] == 2'd2 && level != '0) |=> (level == '0 && word == '0));

   a_r7_entropy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr[3:2] == 2'd3) |-> (bus_rdata == '0));

   a_r8_no_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && level == '0) |=> (level == '0));

   a_r9_load_when_due: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(level[0]) |-> $past(due));

   a_r10_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_sleep && !mix_en) |=> $stable(state));

   a_r10_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_sleep && !take) |=> $stable(word));

   a_r11_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      !eff_sleep |=> (state != '0));
endmodule

bind rng_periph rng_periph_chk #(.W(W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_re    (bus_re),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .go        (go),
   .level     (level),
   .word      (word),
   .state     (state),
   .eff_sleep (eff_sleep),
   .mix_en    (mix_en),
   .take      (take),
   .due       (due)
);

// File: tb/rng_periph_tb.sv
module rng_periph_tb;
   localparam int CLK_PERIOD = 10;
   localparam int GEN        = 32;
   localparam int SEED       = 20240611;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        doze_i = 1'b0;
   logic        noise_i = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rng_periph u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .doze_i(doze_i), .noise_i(noise_i)
   );

   // reference model built from the requirements
   logic        m_go, m_slp, m_lvl;
   logic [31:0] m_out, m_state;
   int          m_cnt;

   function automatic logic [31:0] step(input logic [31:0] s, input logic n);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0] ^ n};
   endfunction

   function automatic logic [31:0] exp_rdata(input logic [3:0] a);
      logic [31:0] r;
      r = '0;
      case (a[3:2])
         2'd0: begin r[0] = m_go; r[4] = m_slp; end
         2'd1: begin r[8] = m_lvl; r[4] = m_slp | doze_i; end
         2'd2: r = m_out;
         default: r = '0;
      endcase
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_go <= 0; m_slp <= 0; m_lvl <= 0; m_out <= '0; m_state <= '0; m_cnt <= 0;
      end else begin
         logic        sl, ld, rd, upd;
         logic [31:0] nx;
         sl  = m_slp | doze_i;
         nx  = m_state;
         upd = 0;
         if (!sl) begin nx = step(m_state, noise_i); upd = 1; end
         if (bus_we && bus_addr[3:2] == 2'd3) begin nx = nx ^ bus_wdata; upd = 1; end
         if (upd && nx == '0) nx = 32'h1;
         m_state <= nx;
         ld = !m_lvl && m_go && !sl && (m_cnt == GEN);
         rd = bus_re && bus_addr[3:2] == 2'd2 && m_lvl;
         if (ld) begin m_lvl <= 1; m_out <= m_state; end
         else if (rd) begin m_lvl <= 0; m_out <= '0; end
         if (ld || rd) m_cnt <= 0;
         else if (!sl && m_cnt != GEN) m_cnt <= m_cnt + 1;
         if (bus_we && bus_addr[3:2] == 2'd0) begin
            m_go  <= m_go | bus_wdata[0];
            m_slp <= bus_wdata[4];
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // one bus cycle; a read is compared with the model in the same cycle
   task automatic cyc(input logic re, input logic we, input logic [3:0] a,
                      input logic [31:0] d, input string tag);
      @(negedge clk);
      bus_re = re; bus_we = we; bus_addr = a; bus_wdata = d;
      noise_i = 1'($urandom % 2);
      #1;
      if (re) check(tag, bus_rdata, exp_rdata(a));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, '0, "idle");
   endtask

   task automatic wait_word(input string tag);
      for (int i = 0; i < 200; i++) begin
         cyc(1, 0, 4'h4, '0, tag);
         if (bus_rdata[8]) break;
      end
      check(tag, {31'b0, bus_rdata[8]}, 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int first;
      void'($urandom(SEED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values, R7 entropy reads zero
      cyc(1, 0, 4'h0, '0, "R1 ctrl");  check("R1 ctrl literal", bus_rdata, 32'h0);
      cyc(1, 0, 4'h4, '0, "R1 stat");  check("R1 stat literal", bus_rdata, 32'h0);
      cyc(1, 0, 4'h8, '0, "R1 out");   check("R1 out literal", bus_rdata, 32'h0);
      cyc(1, 0, 4'hC, '0, "R7 ent");   check("R7 ent literal", bus_rdata, 32'h0);

      // R8 no word without start
      idle(GEN + 10);
      cyc(1, 0, 4'h4, '0, "R8 stat"); check("R8 level idle", bus_rdata, 32'h0);

      // R2 sticky start
      cyc(0, 1, 4'h0, 32'h1, "R2 wr");
      cyc(1, 0, 4'h0, '0, "R2 rd"); check("R2 go set", bus_rdata, 32'h1);
      cyc(0, 1, 4'h0, 32'h0, "R2 wr0");
      cyc(1, 0, 4'h0, '0, "R2 rd0"); check("R2 go sticky", bus_rdata, 32'h1);

      // R5, R6 first word and clear on read
      wait_word("R5 level");
      cyc(1, 0, 4'h8, '0, "R6 word");
      cyc(1, 0, 4'h8, '0, "R6 again"); check("R6 cleared", bus_rdata, 32'h0);
      cyc(1, 0, 4'h4, '0, "R6 stat");  check("R6 level zero", bus_rdata, 32'h0);

      // R9 interval: the clearing read above was two cycles ago, so redo with a clean read
      wait_word("R9 prep");
      cyc(1, 0, 4'h8, '0, "R9 take");
      first = -1;
      for (int i = 1; i <= GEN + 10; i++) begin
         cyc(1, 0, 4'h4, '0, "R9 poll");
         if (bus_rdata[8] && first < 0) first = i;
      end
      check("R9 interval", 32'(first), 32'(GEN + 2));
      cyc(1, 0, 4'h8, '0, "R9 word");

      // R10, R3 sleep by control bit while a word waits
      wait_word("R10 prep");
      cyc(0, 1, 4'h0, 32'h11, "R3 sleep wr");
      cyc(1, 0, 4'h4, '0, "R3 stat"); check("R3 sleep bit", bus_rdata & 32'h10, 32'h10);
      idle(GEN + 5);
      cyc(1, 0, 4'h8, '0, "R10 kept word");
      idle(GEN * 2);
      cyc(1, 0, 4'h4, '0, "R10 stat"); check("R10 no load asleep", bus_rdata, 32'h10);

      // R11 zero the state with an entropy write while asleep
      cyc(0, 1, 4'hC, m_state, "R11 zero");
      cyc(0, 1, 4'h0, 32'h01, "R11 wake");
      wait_word("R11 wait");
      cyc(1, 0, 4'h8, '0, "R11 word");

      // R4 doze
      @(negedge clk); doze_i = 1'b1;
      cyc(1, 0, 4'h4, '0, "R4 stat"); check("R4 sleep bit", bus_rdata & 32'h10, 32'h10);
      cyc(1, 0, 4'h0, '0, "R4 ctrl"); check("R4 ctrl slp clear", bus_rdata, 32'h1);
      idle(GEN * 2);
      cyc(1, 0, 4'h4, '0, "R4 no load"); check("R4 level held", bus_rdata, 32'h10);
      @(negedge clk); doze_i = 1'b0;

      // R7 entropy mixing in normal mode
      cyc(0, 1, 4'hC, 32'hA5A5_0F0F, "R7 mix");
      wait_word("R7 wait");
      cyc(1, 0, 4'h8, '0, "R7 word");

      // random phase against the model
      for (int k = 0; k < 4000; k++) begin
         int op;
         op = $urandom % 16;
         if (op < 6)       cyc(1, 0, 4'(($urandom % 4) * 4), '0, "R9 random read");
         else if (op == 6) cyc(0, 1, 4'h0, $urandom & 32'h11, "R3 random ctrl");
         else if (op == 7) cyc(0, 1, 4'hC, $urandom, "R7 random ent");
         else if (op == 8) begin
            @(negedge clk); doze_i = ($urandom % 4) == 0;
         end else          cyc(1, 0, 4'h8, '0, "R6 random take");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule